// File: doc/BRIEF.md
# Master Clock Source Selector and Prescaler

This block produces a master clock enable pulse by choosing one of three tick sources and dividing it by a power of two. The sources are a slow tick, a main tick and a PLL tick. Every clock in the block is a single-cycle enable pulse inside one synchronous clock domain. The PLL is a behavioural model. Each main tick starts a burst of PLL ticks, and the burst length is a multiplication factor. A write to the PLL configuration clears the lock flag. Lock returns after a fixed number of slow ticks, and no PLL ticks come out until then. A second divider runs from the PLL tick and produces a USB clock enable.

A write to the master clock register changes the source and the prescaler. The new setting does not apply at once. It is held until the running prescaler period ends, and only then replaces the old one. That hand-over keeps the divided output free of shortened periods. A ready flag tells the system whether the current setting is in effect. The flag falls when either field changes and rises after two ticks of the new source. It is also held low whenever the PLL is the chosen source and is not locked. During that time the prescaler is fed from the main tick. An interrupt output follows the ready flag and is gated by an enable input.

Top module: `mck_clk_gen`

## Requirements
- R1: After reset the source is slow and the prescaler divides by 1, so mck_en equals slow_tick. mck_ready is 1, pll_lock is 0, usb_en is 0, and mck_irq equals rdy_irq_en.
- R2: The fields of mck_wdata are decoded as follows.
  - Bits [1:0] select the source: 0 is slow, 1 is main, 3 is PLL, and 2 is treated as slow.
  - Bits [4:2] hold an exponent n, and the source is divided by 2^n. Exponent 7 divides by 64.
  - mck_en pulses on every 2^n-th selected tick, in the same cycle as that tick.
- R3: A changed setting is applied at the end of the current period of the old setting. That final old-setting pulse is still produced. Counting for the new setting then starts from zero.
- R4: mck_ready goes low in the cycle after a write that changes either field. It goes high in the cycle after the second new-source tick that follows the switch point.
- R5: mck_irq is high exactly when mck_ready and rdy_irq_en are both high.
- R6: A write whose two fields equal the last written values leaves mck_ready unchanged. A changing write that arrives while mck_ready is low restarts the switching sequence with the new values.
- R7: pll_lock is low from the cycle after pll_wr. It rises in the cycle after the 8th slow tick that follows the write.
- R8: Each main tick reloads a burst of PLL ticks, one per cycle starting in the next cycle. The burst length is the multiplier in pll_wdata[3:0] from the latest PLL write. No PLL ticks occur while pll_lock is low.
- R9: While the PLL is the applied source and pll_lock is low, mck_ready is low and the prescaler counts main ticks instead.
- R10: pll_wdata[5:4] set the USB divider on the PLL tick: 0 divides by 1, 1 by 2, and 2 or 3 by 4. A PLL write clears the USB divider count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | Slow source enable pulse |
| main_tick | input | 1 | Main source enable pulse |
| mck_wr | input | 1 | Write strobe for the master clock setting |
| mck_wdata | input | 5 | Source select [1:0] and prescaler exponent [4:2] |
| pll_wr | input | 1 | Write strobe for the PLL configuration |
| pll_wdata | input | MUL_W+2 | Multiplier [MUL_W-1:0] and USB divider code [MUL_W+1:MUL_W] |
| rdy_irq_en | input | 1 | Enables the ready interrupt |
| mck_en | output | 1 | Master clock enable pulse |
| usb_en | output | 1 | USB clock enable pulse |
| pll_lock | output | 1 | PLL lock flag |
| mck_ready | output | 1 | The current setting is in effect |
| mck_irq | output | 1 | Ready interrupt |

## Verification
The assertions rely on two properties of the inputs. Each tick input is a single-cycle pulse in the clock domain. The gap between main ticks is at least as long as the PLL multiplier, so PLL bursts do not merge silently. The stimulus generates each tick from a fixed period counter and uses multipliers smaller than the main period. One final phase deliberately shortens the main period below the multiplier to check reloading. Writes arrive at arbitrary cycles, including while a switch is pending and while the PLL is relocking. This tests the restart and fallback paths under the same input assumptions.

// File: rtl/mck_pkg.sv
package mck_pkg;
  localparam int EXP_W = 3;

  typedef enum logic [1:0] {
    SRC_SLOW = 2'd0,
    SRC_MAIN = 2'd1,
    SRC_RSVD = 2'd2,
    SRC_PLL  = 2'd3
  } mck_src_e;
endpackage

// File: rtl/mck_pll_model.sv
module mck_pll_model #(
  parameter int LOCK_TICKS = 8,
  parameter int MUL_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             main_tick,
  input  logic             pll_wr,
  input  logic [MUL_W-1:0] pll_mul,
  output logic             pll_tick,
  output logic             locked
);
  localparam int LCNT_W = $clog2(LOCK_TICKS + 1);

  logic              locked_q, locked_d;
  logic [LCNT_W-1:0] lock_cnt_q, lock_cnt_d;
  logic [MUL_W-1:0]  mul_q, mul_d;
  logic [MUL_W-1:0]  burst_q, burst_d;

  always_comb begin
    locked_d   = locked_q;
    lock_cnt_d = lock_cnt_q;
    mul_d      = mul_q;
    if (pll_wr) begin
      locked_d   = 1'b0;
      lock_cnt_d = LCNT_W'(LOCK_TICKS);
      mul_d      = pll_mul;
    end else if (slow_tick && (lock_cnt_q != '0)) begin
      lock_cnt_d = lock_cnt_q - 1'b1;
      if (lock_cnt_q == LCNT_W'(1)) locked_d = 1'b1;
    end
    if (main_tick)            burst_d = mul_q;
    else if (burst_q != '0)   burst_d = burst_q - 1'b1;
    else                      burst_d = burst_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q   <= 1'b0;
      lock_cnt_q <= '0;
      mul_q      <= '0;
      burst_q    <= '0;
    end else begin
      locked_q   <= locked_d;
      lock_cnt_q <= lock_cnt_d;
      mul_q      <= mul_d;
      burst_q    <= burst_d;
    end
  end

  assign pll_tick = locked_q && (burst_q != '0);
  assign locked   = locked_q;
endmodule

// File: rtl/mck_div_cnt.sv
module mck_div_cnt #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         clear,
  input  logic [W-1:0] lim,
  output logic         pulse
);
  logic [W-1:0] cnt_q, cnt_d;

  assign pulse = tick && (cnt_q >= lim);

  always_comb begin
    cnt_d = cnt_q;
    if (clear)      cnt_d = '0;
    else if (tick)  cnt_d = pulse ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mck_switch_ctl.sv
module mck_switch_ctl
  import mck_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  mck_src_e         wsrc,
  input  logic [EXP_W-1:0] wexp,
  input  logic             period_end,
  input  logic             src_tick,
  output mck_src_e         act_src,
  output logic [EXP_W-1:0] act_exp,
  output logic             rdy
);
  mck_src_e         req_src_q, req_src_d, act_src_q, act_src_d;
  logic [EXP_W-1:0] req_exp_q, req_exp_d, act_exp_q, act_exp_d;
  logic             pend_q, pend_d, settle_q, settle_d, scnt_q, scnt_d;
  logic             rdy_q, rdy_d;
  logic             changed;

  assign changed = wr && ((wsrc != req_src_q) || (wexp != req_exp_q));

  always_comb begin
    req_src_d = req_src_q;
    req_exp_d = req_exp_q;
    act_src_d = act_src_q;
    act_exp_d = act_exp_q;
    pend_d    = pend_q;
    settle_d  = settle_q;
    scnt_d    = scnt_q;
    rdy_d     = rdy_q;
    if (changed) begin
      req_src_d = wsrc;
      req_exp_d = wexp;
      pend_d    = 1'b1;
      settle_d  = 1'b0;
      scnt_d    = 1'b0;
      rdy_d     = 1'b0;
    end else if (pend_q && period_end) begin
      act_src_d = req_src_q;
      act_exp_d = req_exp_q;
      pend_d    = 1'b0;
      settle_d  = 1'b1;
      scnt_d    = 1'b0;
    end else if (settle_q && src_tick) begin
      if (scnt_q) begin
        settle_d = 1'b0;
        rdy_d    = 1'b1;
      end else begin
        scnt_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_src_q <= SRC_SLOW;
      req_exp_q <= '0;
      act_src_q <= SRC_SLOW;
      act_exp_q <= '0;
      pend_q    <= 1'b0;
      settle_q  <= 1'b0;
      scnt_q    <= 1'b0;
      rdy_q     <= 1'b1;
    end else begin
      req_src_q <= req_src_d;
      req_exp_q <= req_exp_d;
      act_src_q <= act_src_d;
      act_exp_q <= act_exp_d;
      pend_q    <= pend_d;
      settle_q  <= settle_d;
      scnt_q    <= scnt_d;
      rdy_q     <= rdy_d;
    end
  end

  assign act_src = act_src_q;
  assign act_exp = act_exp_q;
  assign rdy     = rdy_q;
endmodule

// File: rtl/mck_clk_gen.sv
module mck_clk_gen
  import mck_pkg::*;
#(
  parameter int LOCK_TICKS = 8,
  parameter int MUL_W      = 4,
  parameter int MAX_EXP    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             main_tick,
  input  logic             mck_wr,
  input  logic [4:0]       mck_wdata,
  input  logic             pll_wr,
  input  logic [MUL_W+1:0] pll_wdata,
  input  logic             rdy_irq_en,
  output logic             mck_en,
  output logic             usb_en,
  output logic             pll_lock,
  output logic             mck_ready,
  output logic             mck_irq
);
  localparam int CNT_W = MAX_EXP;
  localparam int USB_W = 2;

  logic             pll_tick;
  logic             locked;
  logic             src_tick;
  mck_src_e         act_src;
  logic [EXP_W-1:0] act_exp;
  logic [EXP_W-1:0] exp_eff;
  logic [CNT_W:0]   lim_wide;
  logic [CNT_W-1:0] mck_lim;
  logic             rdy_raw;
  logic [1:0]       usb_sel_q, usb_sel_d;
  logic [USB_W-1:0] usb_lim;

  mck_pll_model #(.LOCK_TICKS(LOCK_TICKS), .MUL_W(MUL_W)) u_pll (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick),
    .main_tick (main_tick),
    .pll_wr    (pll_wr),
    .pll_mul   (pll_wdata[MUL_W-1:0]),
    .pll_tick  (pll_tick),
    .locked    (locked)
  );

  always_comb begin
    case (act_src)
      SRC_MAIN: src_tick = main_tick;
      SRC_PLL:  src_tick = locked ? pll_tick : main_tick;
      default:  src_tick = slow_tick;
    endcase
  end

  assign exp_eff  = (act_exp > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : act_exp;
  assign lim_wide = ((CNT_W+1)'(1) << exp_eff) - 1'b1;
  assign mck_lim  = lim_wide[CNT_W-1:0];

  mck_div_cnt #(.W(CNT_W)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (src_tick),
    .clear (1'b0),
    .lim   (mck_lim),
    .pulse (mck_en)
  );

  mck_switch_ctl u_sw (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (mck_wr),
    .wsrc       (mck_src_e'(mck_wdata[1:0])),
    .wexp       (mck_wdata[4:2]),
    .period_end (mck_en),
    .src_tick   (src_tick),
    .act_src    (act_src),
    .act_exp    (act_exp),
    .rdy        (rdy_raw)
  );

  always_comb begin
    usb_sel_d = pll_wr ? pll_wdata[MUL_W+1:MUL_W] : usb_sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) usb_sel_q <= '0;
    else        usb_sel_q <= usb_sel_d;
  end

  always_comb begin
    case (usb_sel_q)
      2'd0:    usb_lim = USB_W'(0);
      2'd1:    usb_lim = USB_W'(1);
      default: usb_lim = USB_W'(3);
    endcase
  end

  mck_div_cnt #(.W(USB_W)) u_usb (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (pll_tick),
    .clear (pll_wr),
    .lim   (usb_lim),
    .pulse (usb_en)
  );

  assign pll_lock  = locked;
  assign mck_ready = rdy_raw && !((act_src == SRC_PLL) && !locked);
  assign mck_irq   = rdy_irq_en && mck_ready;
endmodule

// File: rtl/mck_clk_gen_chk.sv
module mck_clk_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       slow_tick,
  input logic       main_tick,
  input logic       pll_wr,
  input logic       rdy_irq_en,
  input logic       mck_en,
  input logic       usb_en,
  input logic       pll_lock,
  input logic       mck_ready,
  input logic       mck_irq,
  input logic [1:0] act_src,
  input logic       pll_tick
);
  a_r7_unlock_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    pll_wr |=> !pll_lock);

  a_r7_lock_on_slow_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_lock) |-> $past(slow_tick));

  a_r8_no_pll_tick_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_lock |-> !pll_tick);

  a_r10_usb_from_pll: assert property (@(posedge clk) disable iff (!rst_n)
    usb_en |-> pll_tick);

  a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    mck_irq |-> (rdy_irq_en && mck_ready));

  a_r9_not_ready_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_src == 2'd3) && !pll_lock) |-> !mck_ready);

  a_r2_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    mck_en |-> (slow_tick || main_tick || pll_tick));
endmodule

bind mck_clk_gen mck_clk_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slow_tick  (slow_tick),
  .main_tick  (main_tick),
  .pll_wr     (pll_wr),
  .rdy_irq_en (rdy_irq_en),
  .mck_en     (mck_en),
  .usb_en     (usb_en),
  .pll_lock   (pll_lock),
  .mck_ready  (mck_ready),
  .mck_irq    (mck_irq),
  .act_src    (act_src),
  .pll_tick   (pll_tick)
);

// File: tb/mck_clk_gen_tb_top.sv
module mck_clk_gen_tb_top;
  logic       clk;
  logic       rst_n;
  logic       slow_tick, main_tick;
  logic       mck_wr, pll_wr, rdy_irq_en;
  logic [4:0] mck_wdata;
  logic [5:0] pll_wdata;
  logic       mck_en, usb_en, pll_lock, mck_ready, mck_irq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int slow_p = 16;
  int main_p = 6;
  bit done   = 0;

  // behavioural reference state
  int m_req_src, m_req_exp, m_act_src, m_act_exp;
  int m_pend, m_settle, m_rdy, m_cnt;
  int m_locked, m_lock_left, m_mul, m_burst, m_usb, m_ucnt;

  mck_clk_gen dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .slow_tick  (slow_tick),
    .main_tick  (main_tick),
    .mck_wr     (mck_wr),
    .mck_wdata  (mck_wdata),
    .pll_wr     (pll_wr),
    .pll_wdata  (pll_wdata),
    .rdy_irq_en (rdy_irq_en),
    .mck_en     (mck_en),
    .usb_en     (usb_en),
    .pll_lock   (pll_lock),
    .mck_ready  (mck_ready),
    .mck_irq    (mck_irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int pow2(input int e);
    int k;
    k = (e > 6) ? 6 : e;
    return 1 << k;
  endfunction

  task automatic model_reset();
    m_req_src = 0; m_req_exp = 0; m_act_src = 0; m_act_exp = 0;
    m_pend = 0; m_settle = 0; m_rdy = 1; m_cnt = 0;
    m_locked = 0; m_lock_left = 0; m_mul = 0; m_burst = 0; m_usb = 0; m_ucnt = 0;
  endtask

  task automatic step(input bit wr, input logic [4:0] wd, input bit pw, input logic [5:0] pd);
    int ptick, stick, e_mck, e_usb, udiv, rdy_o, old_mul;
    @(posedge clk);
    #1;
    cyc++;
    slow_tick = ((cyc % slow_p) == 0);
    main_tick = ((cyc % main_p) == 0);
    mck_wr    = wr;
    mck_wdata = wd;
    pll_wr    = pw;
    pll_wdata = pd;
    #1;
    ptick = (m_locked != 0 && m_burst > 0) ? 1 : 0;
    if (m_act_src == 1)      stick = main_tick;
    else if (m_act_src == 3) stick = m_locked ? ptick : int'(main_tick);
    else                     stick = slow_tick;
    e_mck = (stick != 0 && m_cnt == pow2(m_act_exp) - 1) ? 1 : 0;
    udiv  = (m_usb == 0) ? 1 : (m_usb == 1) ? 2 : 4;
    e_usb = (ptick != 0 && m_ucnt == udiv - 1) ? 1 : 0;
    rdy_o = (m_rdy != 0 && !(m_act_src == 3 && m_locked == 0)) ? 1 : 0;
    chk("R2 R3 mck_en", int'(mck_en), e_mck);
    chk("R4 R9 mck_ready", int'(mck_ready), rdy_o);
    chk("R5 mck_irq", int'(mck_irq), (rdy_irq_en && rdy_o != 0) ? 1 : 0);
    chk("R7 pll_lock", int'(pll_lock), m_locked);
    chk("R8 R10 usb_en", int'(usb_en), e_usb);
    // state advance for the coming edge
    old_mul = m_mul;
    if (pw) begin
      m_locked = 0; m_lock_left = 8; m_mul = int'(pd[3:0]); m_usb = int'(pd[5:4]);
    end else if (m_lock_left > 0 && slow_tick) begin
      m_lock_left--;
      if (m_lock_left == 0) m_locked = 1;
    end
    if (main_tick) m_burst = old_mul;
    else if (m_burst > 0) m_burst--;
    if (pw) m_ucnt = 0;
    else if (ptick != 0) m_ucnt = e_usb ? 0 : m_ucnt + 1;
    if (stick != 0) m_cnt = e_mck ? 0 : m_cnt + 1;
    if (wr && ((int'(wd[1:0]) != m_req_src) || (int'(wd[4:2]) != m_req_exp))) begin
      m_req_src = (wd[1:0] == 2'd2) ? 2 : int'(wd[1:0]);
      m_req_exp = int'(wd[4:2]);
      m_pend = 1; m_settle = 0; m_rdy = 0;
    end else if (m_pend != 0 && e_mck != 0) begin
      m_act_src = (m_req_src == 2) ? 0 : m_req_src;
      m_act_exp = m_req_exp;
      m_pend = 0; m_settle = 2;
    end else if (m_settle > 0 && stick != 0) begin
      m_settle--;
      if (m_settle == 0) m_rdy = 1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 5'd0, 1'b0, 6'd0);
  endtask

  task automatic wr_mck(input int src, input int e);
    step(1'b1, {3'(e), 2'(src)}, 1'b0, 6'd0);
  endtask

  task automatic wr_pll(input int usb, input int mul);
    step(1'b0, 5'd0, 1'b1, {2'(usb), 4'(mul)});
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; slow_tick = 0; main_tick = 0; mck_wr = 0; pll_wr = 0;
    mck_wdata = '0; pll_wdata = '0; rdy_irq_en = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: state held during reset
    chk("R1 ready at reset", int'(mck_ready), 1);
    chk("R1 lock at reset", int'(pll_lock), 0);
    chk("R1 usb at reset", int'(usb_en), 0);
    rst_n = 1'b1;
    idle(40);                       // R1 mck follows slow tick
    wr_mck(0, 2);                   // R2 R3 R4 slow /4
    idle(200);
    wr_mck(0, 2);                   // R6 unchanged write
    idle(3);
    chk("R6 ready kept after same write", int'(mck_ready), 1);
    wr_mck(1, 3);                   // main /8
    idle(150);
    rdy_irq_en = 1'b1;              // R5
    wr_mck(1, 7);                   // R2 reserved exponent
    idle(3);
    wr_mck(1, 1);                   // R6 restart while not ready
    idle(60);
    wr_mck(1, 7);
    idle(500);
    wr_pll(1, 3);                   // R7 R8 R10
    idle(2);
    chk("R7 lock cleared after write", int'(pll_lock), 0);
    idle(160);
    chk("R7 lock regained", int'(pll_lock), 1);
    wr_mck(3, 1);                   // PLL /2
    idle(120);
    wr_pll(2, 2);                   // R9 relock while selected
    idle(3);
    chk("R9 not ready while relocking", int'(mck_ready), 0);
    idle(200);
    wr_mck(2, 4);                   // R2 reserved source code
    idle(200);
    wr_pll(3, 4);
    wr_mck(3, 0);                   // R9 select PLL while unlocked
    idle(250);
    rdy_irq_en = 1'b0;
    slow_p = 3; main_p = 2;         // R8 overlapping bursts
    wr_pll(0, 5);
    idle(120);
    wr_mck(1, 0);
    idle(40);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule